// File: doc/BRIEF.md
# Serial Receive Error Status Unit

This unit sits behind the bit-level deserialiser of an asynchronous serial receiver. For each received frame it takes the data bits, the parity bit and the sampled stop bits. It checks them against the line configuration (data length, parity sense, number of stop bits) and passes the character on. A separate overrun pulse from the receiver's buffer logic is also taken in. Parity, framing and overrun errors are kept as sticky flags in a read-only status word, and any of them raises a level error interrupt.

Software never writes the flags directly. A write-one-to-act command word clears each error flag on its own, and sets or clears the receiver enable. Each error class is recorded only when its check enable in the configuration word is set. While the receiver is disabled, frames are dropped and nothing is recorded. Characters that carry a parity or framing error are still delivered. Overrun is reported only through its flag and never alters the character delivered in the same cycle.

Top module: `uart_rx_err_status`

## Requirements
- R1: After reset, the status word is all zero, `rx_enable` is 0, `err_irq` is 0 and `char_valid` is 0.
- R2: A command write with bit 1 set makes `rx_enable` 1, and a command write with bit 0 set makes it 0. If both bits are written together, `rx_enable` becomes 1. Command bits written as 0 change nothing.
- R3: When check enable bit 20 of `ctrl_word` is set, a frame whose parity does not match sets status bit 16 one cycle after the frame. The parity sense is even when `ctrl_word` bit 5 is 0 and odd when it is 1. It is computed over the active data bits plus the parity bit.
- R4: When check enable bit 17 is set, status bit 17 is set if the first stop bit (`frame_stop[0]`) is 0. With `ctrl_word` bit 7 set (two stop bits), it is also set if the second stop bit (`frame_stop[1]`) is 0. With bit 7 clear, the second stop bit is ignored.
- R5: When check enable bit 19 is set, an `ovr_pulse` sets status bit 19. A frame accepted in the same cycle is delivered unchanged and raises neither parity nor framing error on its own.
- R6: An error whose check enable (bit 20 parity, bit 17 framing, bit 19 overrun) is clear is never recorded.
- R7: The error flags are sticky. Command bit 2 clears only the parity flag, bit 3 clears only the framing flag, and bit 5 clears only the overrun flag.
- R8: If an error event and the command clearing that flag arrive in the same cycle, the flag is set afterwards.
- R9: While `rx_enable` is 0, frames produce no `char_valid`, and neither frames nor overrun pulses record any error.
- R10: `ctrl_word[2:0]` equal to 2 selects 7-bit frames: bit 7 of the delivered character is 0, and parity covers only bits 6..0. Any other value, including 0, selects 8-bit frames.
- R11: `err_irq` is 1 exactly when at least one of status bits 16, 17 and 19 is 1. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Line configuration and error check enables |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Write-one-to-act command bits |
| frame_valid | input | 1 | A frame from the deserialiser is present this cycle |
| frame_data | input | 8 | Received data bits |
| frame_par | input | 1 | Received parity bit |
| frame_stop | input | 2 | Sampled stop bits, index 0 first |
| ovr_pulse | input | 1 | Receive overrun event |
| char_valid | output | 1 | Delivered character valid (one cycle) |
| char_data | output | 8 | Delivered character |
| rx_enable | output | 1 | Receiver enable flag |
| status_word | output | 32 | Sticky error flags at bits 16, 17, 19 |
| err_irq | output | 1 | Error interrupt, OR of the flags |

## Verification
The bench targets the parity sense in 7-bit mode with data bit 7 set. A design that folds bit 7 into the parity would flag a correct frame and would leave bit 7 in the delivered character. It also targets a low second stop bit in one-stop mode, which a design that always checks both stop bits would wrongly report. A clear that arrives in the same cycle as a new error must leave the flag set; a design where the clear wins would lose the error. Overrun arriving together with a clean frame must leave both the character and the other flags untouched. With the receiver disabled, a design that gates only the frame path would still record overruns.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
    localparam int WORD_W       = 32;
    localparam int MODE_LSB     = 0;
    localparam int MODE_W       = 3;
    localparam logic [MODE_W-1:0] MODE_SEVEN = 3'd2;
    localparam int CFG_ODD      = 5;
    localparam int CFG_TWO_STOP = 7;
    localparam int CFG_FRM_EN   = 17;
    localparam int CFG_OVR_EN   = 19;
    localparam int CFG_PAR_EN   = 20;
    localparam int ST_PAR       = 16;
    localparam int ST_FRM       = 17;
    localparam int ST_OVR       = 19;
    localparam int CMD_RXEN_CLR = 0;
    localparam int CMD_RXEN_SET = 1;
    localparam int CMD_PAR_CLR  = 2;
    localparam int CMD_FRM_CLR  = 3;
    localparam int CMD_OVR_CLR  = 5;

    typedef struct packed {
        logic rx_en;
        logic par;
        logic frm;
        logic ovr;
    } flag_state_t;

    typedef struct packed {
        logic odd;
        logic two_stop;
        logic seven;
        logic par_en;
        logic frm_en;
        logic ovr_en;
    } line_cfg_t;
endpackage

// File: rtl/rxes_frame_check.sv
module rxes_frame_check
    import rxes_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  line_cfg_t         cfg,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_par,
    input  logic [1:0]        frame_stop,
    input  logic              ovr_pulse,
    output logic              par_evt,
    output logic              frm_evt,
    output logic              ovr_evt,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t        st_d, st_q;
    logic [DATA_W-1:0] data_eff;
    logic              accept;
    logic              ones_odd;
    logic              stop_bad;

    always_comb begin
        data_eff = frame_data;
        if (cfg.seven) begin
            data_eff[DATA_W-1] = 1'b0;
        end
        accept   = rx_en && frame_valid;
        ones_odd = (^data_eff) ^ frame_par;
        stop_bad = !frame_stop[0] || (cfg.two_stop && !frame_stop[1]);

        par_evt = accept && cfg.par_en && (ones_odd != cfg.odd);
        frm_evt = accept && cfg.frm_en && stop_bad;
        ovr_evt = rx_en && cfg.ovr_en && ovr_pulse;

        st_d       = st_q;
        st_d.valid = accept;
        if (accept) begin
            st_d.data = data_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_valid = st_q.valid;
    assign char_data  = st_q.data;

    // R9: a delivered character always comes from a cycle with the receiver enabled
    assert_char_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(rx_en) && $past(frame_valid));
endmodule

// File: rtl/rxes_err_flags.sv
module rxes_err_flags
    import rxes_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        cmd_rxen_clr,
    input  logic        cmd_rxen_set,
    input  logic        cmd_par_clr,
    input  logic        cmd_frm_clr,
    input  logic        cmd_ovr_clr,
    input  logic        par_evt,
    input  logic        frm_evt,
    input  logic        ovr_evt,
    output flag_state_t flags
);
    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (cmd_wr) begin
            if (cmd_rxen_clr) fl_d.rx_en = 1'b0;
            if (cmd_rxen_set) fl_d.rx_en = 1'b1;
            if (cmd_par_clr)  fl_d.par   = 1'b0;
            if (cmd_frm_clr)  fl_d.frm   = 1'b0;
            if (cmd_ovr_clr)  fl_d.ovr   = 1'b0;
        end
        if (par_evt) fl_d.par = 1'b1;
        if (frm_evt) fl_d.frm = 1'b1;
        if (ovr_evt) fl_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    // R7: parity flag holds until its clear command
    assert_sticky_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.par && !(cmd_wr && cmd_par_clr) |=> fl_q.par);
    // R7: framing flag holds until its clear command
    assert_sticky_frm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.frm && !(cmd_wr && cmd_frm_clr) |=> fl_q.frm);
    // R8: a new event beats a clear in the same cycle
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt && cmd_wr && cmd_ovr_clr |=> fl_q.ovr);
    // R2: set command wins over clear command
    assert_rxen_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_rxen_set |=> fl_q.rx_en);
    // R9: with the receiver off and no command, no flag moves
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_q.rx_en && !cmd_wr |=> $stable(fl_q));
endmodule

// File: rtl/uart_rx_err_status.sv
module uart_rx_err_status
    import rxes_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_par,
    input  logic [1:0]        frame_stop,
    input  logic              ovr_pulse,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              rx_enable,
    output logic [WORD_W-1:0] status_word,
    output logic              err_irq
);
    line_cfg_t   cfg;
    flag_state_t flags;
    logic        par_evt, frm_evt, ovr_evt;
    logic        unused_word_bits;

    always_comb begin
        cfg.odd      = ctrl_word[CFG_ODD];
        cfg.two_stop = ctrl_word[CFG_TWO_STOP];
        cfg.seven    = (ctrl_word[MODE_LSB +: MODE_W] == MODE_SEVEN);
        cfg.par_en   = ctrl_word[CFG_PAR_EN];
        cfg.frm_en   = ctrl_word[CFG_FRM_EN];
        cfg.ovr_en   = ctrl_word[CFG_OVR_EN];
    end

    assign unused_word_bits = ^{ctrl_word, cmd_word};

    rxes_frame_check #(.DATA_W(DATA_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (flags.rx_en),
        .cfg         (cfg),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_par   (frame_par),
        .frame_stop  (frame_stop),
        .ovr_pulse   (ovr_pulse),
        .par_evt     (par_evt),
        .frm_evt     (frm_evt),
        .ovr_evt     (ovr_evt),
        .char_valid  (char_valid),
        .char_data   (char_data)
    );

    rxes_err_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_rxen_clr (cmd_word[CMD_RXEN_CLR]),
        .cmd_rxen_set (cmd_word[CMD_RXEN_SET]),
        .cmd_par_clr  (cmd_word[CMD_PAR_CLR]),
        .cmd_frm_clr  (cmd_word[CMD_FRM_CLR]),
        .cmd_ovr_clr  (cmd_word[CMD_OVR_CLR]),
        .par_evt      (par_evt),
        .frm_evt      (frm_evt),
        .ovr_evt      (ovr_evt),
        .flags        (flags)
    );

    always_comb begin
        status_word         = '0;
        status_word[ST_PAR] = flags.par;
        status_word[ST_FRM] = flags.frm;
        status_word[ST_OVR] = flags.ovr;
    end

    assign rx_enable = flags.rx_en;
    assign err_irq   = flags.par | flags.frm | flags.ovr;

    // R11: the interrupt only rises after an error event reached the flags
    assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(par_evt || frm_evt || ovr_evt));
endmodule

// File: tb/tb_uart_rx_err_status.sv
module tb_uart_rx_err_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        frame_valid = 1'b0;
    logic [7:0]  frame_data = '0;
    logic        frame_par = 1'b0;
    logic [1:0]  frame_stop = 2'b11;
    logic        ovr_pulse = 1'b0;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        rx_enable;
    logic [31:0] status_word;
    logic        err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_rx_err_status dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_par(frame_par), .frame_stop(frame_stop), .ovr_pulse(ovr_pulse),
        .char_valid(char_valid), .char_data(char_data), .rx_enable(rx_enable),
        .status_word(status_word), .err_irq(err_irq)
    );

    // vector: {seven, odd, two_stop, par_en, frm_en, data[8], par, stop[2], exp_char[8], exp_par, exp_frm}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {5'b00011, 8'hA5, 1'b0, 2'b11, 8'hA5, 1'b0, 1'b0},
        {5'b00011, 8'hA5, 1'b1, 2'b11, 8'hA5, 1'b1, 1'b0},
        {5'b01011, 8'hA5, 1'b1, 2'b11, 8'hA5, 1'b0, 1'b0},
        {5'b01011, 8'hA5, 1'b0, 2'b11, 8'hA5, 1'b1, 1'b0},
        {5'b10011, 8'hFF, 1'b1, 2'b11, 8'h7F, 1'b0, 1'b0},
        {5'b10011, 8'h80, 1'b0, 2'b11, 8'h00, 1'b0, 1'b0},
        {5'b00011, 8'h3C, 1'b0, 2'b10, 8'h3C, 1'b0, 1'b1},
        {5'b00011, 8'h3C, 1'b0, 2'b01, 8'h3C, 1'b0, 1'b0},
        {5'b00111, 8'h3C, 1'b0, 2'b01, 8'h3C, 1'b0, 1'b1},
        {5'b00111, 8'h3C, 1'b0, 2'b11, 8'h3C, 1'b0, 1'b0},
        {5'b00001, 8'hA5, 1'b1, 2'b11, 8'hA5, 1'b0, 1'b0},
        {5'b00010, 8'h3C, 1'b0, 2'b00, 8'h3C, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input bit seven, input bit odd, input bit two,
                                            input bit pen, input bit fen, input bit oen);
        logic [31:0] c;
        c = '0;
        c[2:0] = seven ? 3'd2 : 3'd0;
        c[5]   = odd;
        c[7]   = two;
        c[20]  = pen;
        c[17]  = fen;
        c[19]  = oen;
        return c;
    endfunction

    task automatic do_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_word = '0;
    endtask

    // drives one cycle of stimulus; outputs are examined at the following negedge
    task automatic drive(input bit fv, input logic [7:0] d, input bit p,
                         input logic [1:0] s, input bit ov,
                         input bit cw, input logic [31:0] cmd);
        @(negedge clk);
        frame_valid = fv; frame_data = d; frame_par = p; frame_stop = s; ovr_pulse = ov;
        cmd_wr = cw; cmd_word = cmd;
        @(negedge clk);
        frame_valid = 1'b0; ovr_pulse = 1'b0; cmd_wr = 1'b0; cmd_word = '0;
        frame_stop = 2'b11;
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", status_word, 32'h0);
        check("R1 rx_enable", {31'b0, rx_enable}, 32'h0);
        check("R1 err_irq", {31'b0, err_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 char_valid", {31'b0, char_valid}, 32'h0);

        // R2 zero bits do nothing, then set
        do_cmd(32'h0);
        check("R2 zero write", {31'b0, rx_enable}, 32'h0);
        do_cmd(32'h2);
        check("R2 set", {31'b0, rx_enable}, 32'h1);

        // vector table: R3 R4 R6 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            do_cmd(32'h2C);
            ctrl_word = mk_ctrl(v[25], v[24], v[23], v[22], v[21], 1'b1);
            drive(1'b1, v[20:13], v[12], v[11:10], 1'b0, 1'b0, 32'h0);
            check($sformatf("R10 vec%0d char_valid", i), {31'b0, char_valid}, 32'h1);
            check($sformatf("R10 vec%0d char", i), {24'b0, char_data}, {24'b0, v[9:2]});
            check($sformatf("R3 vec%0d parity", i), {31'b0, status_word[16]}, {31'b0, v[1]});
            check($sformatf("R4 vec%0d framing", i), {31'b0, status_word[17]}, {31'b0, v[0]});
            check($sformatf("R11 vec%0d irq", i), {31'b0, err_irq}, {31'b0, v[1] | v[0]});
            check($sformatf("R11 vec%0d other bits", i), status_word & ~32'h000B_0000, 32'h0);
            // R6 vectors 10 and 11 have the check disabled
        end

        // R7 stickiness and individual clears
        do_cmd(32'h2C);
        ctrl_word = mk_ctrl(0, 0, 0, 1, 1, 1);
        drive(1'b1, 8'hA5, 1'b1, 2'b00, 1'b1, 1'b0, 32'h0);
        repeat (4) @(negedge clk);
        check("R7 sticky", status_word, 32'h000B_0000);
        do_cmd(32'h8);
        check("R7 clear frm only", status_word, 32'h0009_0000);
        do_cmd(32'h4);
        check("R7 clear par only", status_word, 32'h0008_0000);
        do_cmd(32'h20);
        check("R7 clear ovr", status_word, 32'h0);

        // R5 overrun with clean frame
        drive(1'b1, 8'h5A, 1'b0, 2'b11, 1'b1, 1'b0, 32'h0);
        check("R5 char intact", {23'b0, char_valid, char_data}, {23'b0, 1'b1, 8'h5A});
        check("R5 ovr only", status_word, 32'h0008_0000);
        do_cmd(32'h20);

        // R6 overrun with check disabled
        ctrl_word = mk_ctrl(0, 0, 0, 1, 1, 0);
        drive(1'b0, 8'h00, 1'b0, 2'b11, 1'b1, 1'b0, 32'h0);
        check("R6 ovr disabled", status_word, 32'h0);

        // R8 event and clear together
        ctrl_word = mk_ctrl(0, 0, 0, 1, 1, 1);
        drive(1'b1, 8'hA5, 1'b1, 2'b11, 1'b0, 1'b1, 32'h4);
        check("R8 par set wins", status_word, 32'h0001_0000);
        drive(1'b0, 8'h00, 1'b0, 2'b11, 1'b1, 1'b1, 32'h20);
        check("R8 ovr set wins", status_word, 32'h0009_0000);
        do_cmd(32'h3);
        check("R2 both bits set wins", {31'b0, rx_enable}, 32'h1);
        do_cmd(32'h2C);

        // R9 disabled receiver
        do_cmd(32'h1);
        check("R2 clear", {31'b0, rx_enable}, 32'h0);
        drive(1'b1, 8'hA5, 1'b1, 2'b00, 1'b1, 1'b0, 32'h0);
        check("R9 no char", {31'b0, char_valid}, 32'h0);
        check("R9 no errors", status_word, 32'h0);
        check("R9 no irq", {31'b0, err_irq}, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule